// File: doc/BRIEF.md
# Two-Stage Audio Clock Divider

This block derives the two clocks an audio serial port needs from one fast source clock. The first stage divides the source down to a codec system clock. The second stage counts the ticks of that system clock and divides them again to give the serial bit clock. A single 32-bit format word sets up both stages. The block also reports which source frequency the word selects and flags a selection that does not exist.

Each stage produces two outputs. One is a single-cycle tick enable in the source-clock domain, which downstream logic uses as a clock enable. The other is a registered square wave, which can drive a pin. Neither divisor field is a plain binary count. A handful of reserved codes give small odd ratios, and every other code gives an even ratio. A new divisor is loaded only at the end of the period that is running, so changing the word never produces a shortened pulse. The bit-clock stage runs only when the word sets master mode.

Top module: `audclk_divider`

## Requirements
- R1: Bits [31:30] of `cfg_word` select the source. Code 0 reports `src_hz` = 18432000, code 1 reports 45158400 and code 2 reports 49152000, each with `cfg_err` low. Code 3 reports `src_hz` = 0 with `cfg_err` high.
- R2: The system-clock divisor field is bits [28:24]. Its reserved codes are 0x14 (ratio 1), 0x13 (ratio 3), 0x12 (ratio 5) and 0x0E (ratio 14). The ratio is the spacing of `mclk_tick` pulses in source cycles.
- R3: Any other system-clock code c gives a `mclk_tick` spacing of 2*(c+1) source cycles.
- R4: The bit-clock divisor field is bits [23:20]. Code 8 gives ratio 1, code 9 gives ratio 3, and any other code c gives 2*(c+1). `sclk_tick` pulses are spaced by the product of the two ratios in source cycles, and each one falls in a cycle where `mclk_tick` is also high.
- R5: When bit 19 (master) is clear, `sclk_tick` and `sclk_wave` stay low while `mclk_tick` keeps running.
- R6: For a ratio N > 1, each square-wave output is high for floor(N/2) of its input ticks and low for the remaining ticks. The wave changes only on an input tick. For `sclk_wave` this means it is high for floor(Ns/2)*Nm source cycles.
- R7: A changed divisor takes effect only when the running period of that stage completes. A word written in the terminal cycle of a period governs the very next period.
- R8: At a system-clock ratio of 1, `mclk_tick` is high in every cycle and `mclk_wave` stays low.
- R9: Synchronous reset clears both counters and drives both waves low. After reset is released, the first `mclk_tick` comes Nm-1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Serial-format control word |
| src_hz | output | 26 | Decoded source frequency in Hz, 0 if illegal |
| cfg_err | output | 1 | Illegal source selection |
| mclk_tick | output | 1 | System-clock tick enable |
| mclk_wave | output | 1 | System-clock square wave |
| sclk_tick | output | 1 | Bit-clock tick enable |
| sclk_wave | output | 1 | Bit-clock square wave |

## Verification
Two events can land in the same source cycle: the terminal count of a stage and a write of a new divisor. The bench provokes this by changing the word on the exact cycle in which `mclk_tick` is high. It judges the result by requiring that the very next tick spacing already equals the new ratio. A second test writes one cycle after the terminal count and expects the old ratio to complete first. A third coincidence is the bit-clock terminal count, which always falls on a system-clock tick. The bench checks this by measuring `sclk_tick` spacings as exact ratio products across the vector sweep.

// File: rtl/audclk_pkg.sv
`timescale 1ns/1ps
package audclk_pkg;
    localparam int CFG_W      = 32;
    localparam int SRC_LSB    = 30;
    localparam int MDIV_LSB   = 24;
    localparam int MDIV_W     = 5;
    localparam int SDIV_LSB   = 20;
    localparam int SDIV_W     = 4;
    localparam int MASTER_BIT = 19;
    localparam int RATIO_W    = MDIV_W + 2;
    localparam int HZ_W       = 26;

    typedef enum logic [1:0] {
        SRC_18M = 2'd0,
        SRC_45M = 2'd1,
        SRC_49M = 2'd2,
        SRC_BAD = 2'd3
    } src_sel_e;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        src_sel_e src;
        ratio_t   mdiv;
        ratio_t   sdiv;
        logic     master;
    } clk_cfg_t;

    // even ratio 2*(c+1) for a code zero-extended to the system-clock field width
    function automatic ratio_t even_ratio(input logic [MDIV_W-1:0] c);
        return ratio_t'({c, 1'b0}) + ratio_t'(2);
    endfunction

    function automatic ratio_t mclk_ratio(input logic [MDIV_W-1:0] c);
        case (c)
            5'h14:   return ratio_t'(1);
            5'h13:   return ratio_t'(3);
            5'h12:   return ratio_t'(5);
            5'h0E:   return ratio_t'(14);
            default: return even_ratio(c);
        endcase
    endfunction

    function automatic ratio_t sclk_ratio(input logic [SDIV_W-1:0] c);
        case (c)
            4'd8:    return ratio_t'(1);
            4'd9:    return ratio_t'(3);
            default: return even_ratio({{(MDIV_W-SDIV_W){1'b0}}, c});
        endcase
    endfunction

    function automatic logic [HZ_W-1:0] src_freq(input src_sel_e s);
        case (s)
            SRC_18M: return HZ_W'(18432000);
            SRC_45M: return HZ_W'(45158400);
            SRC_49M: return HZ_W'(49152000);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/audclk_cfg_decode.sv
`timescale 1ns/1ps
module audclk_cfg_decode
    import audclk_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output clk_cfg_t         cfg,
    output logic [HZ_W-1:0]  src_hz,
    output logic             cfg_err
);
    logic unused_cfg_bits;

    always_comb begin
        cfg.src    = src_sel_e'(cfg_word[SRC_LSB +: 2]);
        cfg.mdiv   = mclk_ratio(cfg_word[MDIV_LSB +: MDIV_W]);
        cfg.sdiv   = sclk_ratio(cfg_word[SDIV_LSB +: SDIV_W]);
        cfg.master = cfg_word[MASTER_BIT];
    end

    assign src_hz  = src_freq(cfg.src);
    assign cfg_err = (cfg.src == SRC_BAD);

    assign unused_cfg_bits = ^{cfg_word[MDIV_LSB+MDIV_W +: 1], cfg_word[MASTER_BIT-1:0]};
endmodule

// File: rtl/audclk_div_stage.sv
`timescale 1ns/1ps
module audclk_div_stage #(
    parameter int RATIO_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               tick_in,
    input  logic [RATIO_W-1:0] ratio_req,
    output logic               tick_out,
    output logic               wave
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] ratio_cur;
    logic [RATIO_W-1:0] cnt_nx;
    logic [RATIO_W-1:0] low_len;
    logic               term;

    assign term     = (cnt == ratio_cur - RATIO_W'(1));
    assign cnt_nx   = cnt + RATIO_W'(1);
    assign low_len  = ratio_cur - (ratio_cur >> 1);
    assign tick_out = tick_in & term;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt       <= '0;
            ratio_cur <= ratio_req;
            wave      <= 1'b0;
        end else if (tick_in) begin
            if (term) begin
                cnt       <= '0;
                ratio_cur <= ratio_req;
                wave      <= 1'b0;
            end else begin
                cnt  <= cnt_nx;
                wave <= (cnt_nx >= low_len);
            end
        end
    end

    // R7: the active ratio only moves at a completed period
    assert_reload_at_terminal_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clr) && !$past(tick_out)) |-> $stable(ratio_cur));

    // R6: the square wave only moves on an input tick
    assert_wave_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(clr) && !$past(tick_in)) |-> $stable(wave));

    // R3: the counter never passes the active ratio
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt < ratio_cur);
endmodule

// File: rtl/audclk_divider.sv
`timescale 1ns/1ps
module audclk_divider
    import audclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      cfg_word,
    output logic [25:0]      src_hz,
    output logic             cfg_err,
    output logic             mclk_tick,
    output logic             mclk_wave,
    output logic             sclk_tick,
    output logic             sclk_wave
);
    clk_cfg_t cfg;
    logic     sclk_en;

    audclk_cfg_decode u_dec (
        .cfg_word (cfg_word),
        .cfg      (cfg),
        .src_hz   (src_hz),
        .cfg_err  (cfg_err)
    );

    audclk_div_stage #(.RATIO_W(RATIO_W)) u_mstage (
        .clk       (clk),
        .rst       (rst),
        .clr       (1'b0),
        .tick_in   (1'b1),
        .ratio_req (cfg.mdiv),
        .tick_out  (mclk_tick),
        .wave      (mclk_wave)
    );

    assign sclk_en = mclk_tick & cfg.master;

    audclk_div_stage #(.RATIO_W(RATIO_W)) u_sstage (
        .clk       (clk),
        .rst       (rst),
        .clr       (~cfg.master),
        .tick_in   (sclk_en),
        .ratio_req (cfg.sdiv),
        .tick_out  (sclk_tick),
        .wave      (sclk_wave)
    );

    // R4: a bit-clock tick always lands on a system-clock tick
    assert_sclk_on_mclk_R4: assert property (@(posedge clk) disable iff (rst)
        sclk_tick |-> mclk_tick);

    // R5: with master clear for two cycles the bit clock is idle
    assert_slave_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_word[MASTER_BIT]) && !cfg_word[MASTER_BIT]) |-> (!sclk_tick && !sclk_wave));

    // R9: waves are low right after a reset cycle
    assert_reset_low_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mclk_wave && !sclk_wave));
endmodule

// File: tb/audclk_divider_bench.sv
`timescale 1ns/1ps
module audclk_divider_bench;
    localparam int LIMIT = 20000;

    // {mclk code, sclk code, expected mclk ratio, expected sclk ratio}
    localparam logic [31:0] VEC [32] = '{
        {8'd0,  8'd0, 8'd2,  8'd2},  {8'd1,  8'd1, 8'd4,  8'd4},
        {8'd2,  8'd2, 8'd6,  8'd6},  {8'd3,  8'd3, 8'd8,  8'd8},
        {8'd4,  8'd4, 8'd10, 8'd10}, {8'd5,  8'd5, 8'd12, 8'd12},
        {8'd6,  8'd6, 8'd14, 8'd14}, {8'd7,  8'd7, 8'd16, 8'd16},
        {8'd8,  8'd8, 8'd18, 8'd1},  {8'd9,  8'd9, 8'd20, 8'd3},
        {8'd10, 8'd0, 8'd22, 8'd2},  {8'd11, 8'd1, 8'd24, 8'd4},
        {8'd12, 8'd2, 8'd26, 8'd6},  {8'd13, 8'd3, 8'd28, 8'd8},
        {8'd14, 8'd4, 8'd14, 8'd10}, {8'd15, 8'd5, 8'd32, 8'd12},
        {8'd16, 8'd6, 8'd34, 8'd14}, {8'd17, 8'd7, 8'd36, 8'd16},
        {8'd18, 8'd8, 8'd5,  8'd1},  {8'd19, 8'd9, 8'd3,  8'd3},
        {8'd20, 8'd0, 8'd1,  8'd2},  {8'd21, 8'd1, 8'd44, 8'd4},
        {8'd22, 8'd2, 8'd46, 8'd6},  {8'd23, 8'd3, 8'd48, 8'd8},
        {8'd24, 8'd4, 8'd50, 8'd10}, {8'd25, 8'd5, 8'd52, 8'd12},
        {8'd26, 8'd6, 8'd54, 8'd14}, {8'd27, 8'd7, 8'd56, 8'd16},
        {8'd28, 8'd8, 8'd58, 8'd1},  {8'd29, 8'd9, 8'd60, 8'd3},
        {8'd30, 8'd0, 8'd62, 8'd2},  {8'd31, 8'd1, 8'd64, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic [25:0] src_hz;
    logic        cfg_err, mclk_tick, mclk_wave, sclk_tick, sclk_wave;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    audclk_divider u_audclk_divider (
        .clk       (clk),
        .rst       (rst),
        .cfg_word  (cfg_word),
        .src_hz    (src_hz),
        .cfg_err   (cfg_err),
        .mclk_tick (mclk_tick),
        .mclk_wave (mclk_wave),
        .sclk_tick (sclk_tick),
        .sclk_wave (sclk_wave)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int src, input int m, input int s, input bit ms);
        logic [1:0] sv = src[1:0];
        logic [4:0] mv = m[4:0];
        logic [3:0] cv = s[3:0];
        return {sv, 1'b0, mv, cv, ms, 19'b0};
    endfunction

    function automatic logic tk(input int sel);
        return (sel == 0) ? mclk_tick : sclk_tick;
    endfunction

    function automatic logic wv(input int sel);
        return (sel == 0) ? mclk_wave : sclk_wave;
    endfunction

    task automatic wait_tick(input int sel, output int n);
        n = 0;
        while (!tk(sel) && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic next_tick(input int sel, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tk(sel) && n < LIMIT);
    endtask

    task automatic high_len(input int sel, output int h);
        int g = 0;
        while (wv(sel) && g < LIMIT) begin @(negedge clk); g++; end
        while (!wv(sel) && g < LIMIT) begin @(negedge clk); g++; end
        h = 0;
        while (wv(sel) && h < LIMIT) begin @(negedge clk); h++; end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int n, g, h;
        int em, es, mc, sc;
        logic [25:0] hz_exp [4];
        hz_exp[0] = 26'd18432000;
        hz_exp[1] = 26'd45158400;
        hz_exp[2] = 26'd49152000;
        hz_exp[3] = 26'd0;

        // R9: reset state
        cfg_word = mk(0, 1, 0, 1'b1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mclk_wave && !sclk_wave && !sclk_tick, "R9 reset outputs low",
            {mclk_wave, sclk_wave, sclk_tick}, 0);

        // R1: source decode and error flag
        for (int k = 0; k < 4; k++) begin
            cfg_word = mk(k, 1, 0, 1'b1);
            #1;
            chk(src_hz == hz_exp[k], "R1 source frequency", src_hz, hz_exp[k]);
            chk(cfg_err == (k == 3), "R1 error flag", cfg_err, (k == 3));
        end
        @(negedge clk);

        // sweep of all system-clock codes, bit-clock codes 0..9
        for (int i = 0; i < 32; i++) begin
            mc = int'(VEC[i][31:24]);
            sc = int'(VEC[i][23:16]);
            em = int'(VEC[i][15:8]);
            es = int'(VEC[i][7:0]);
            cfg_word = mk(0, mc, sc, 1'b1);
            do_reset();
            wait_tick(0, n);
            chk(n == em - 1, "R9 first tick latency", n, em - 1);
            next_tick(0, g);
            if (mc == 20 || mc == 19 || mc == 18 || mc == 14)
                chk(g == em, "R2 reserved mclk ratio", g, em);
            else
                chk(g == em, "R3 even mclk ratio", g, em);
            wait_tick(1, n);
            next_tick(1, g);
            chk(g == em * es, "R4 sclk spacing product", g, em * es);
            if (em > 1) begin
                high_len(0, h);
                chk(h == em / 2, "R6 mclk duty", h, em / 2);
            end
            if (es > 1) begin
                high_len(1, h);
                chk(h == (es / 2) * em, "R6 sclk duty", h, (es / 2) * em);
            end
        end

        // R8: ratio 1 ticks every cycle, wave low
        cfg_word = mk(0, 20, 0, 1'b1);
        do_reset();
        n = 0;
        for (int c = 0; c < 20; c++) begin
            if (mclk_tick && !mclk_wave) n++;
            @(negedge clk);
        end
        chk(n == 20, "R8 every-cycle tick", n, 20);

        // R5: master clear keeps bit clock idle, system clock runs
        cfg_word = mk(0, 1, 0, 1'b0);
        do_reset();
        n = 0;
        g = 0;
        for (int c = 0; c < 300; c++) begin
            if (sclk_tick || sclk_wave) n++;
            if (mclk_tick) g++;
            @(negedge clk);
        end
        chk(n == 0, "R5 sclk idle", n, 0);
        chk(g == 75, "R5 mclk still running", g, 75);

        // R7: write one cycle after terminal count, old period completes
        cfg_word = mk(0, 1, 0, 1'b1);
        do_reset();
        wait_tick(0, n);
        @(negedge clk);
        cfg_word = mk(0, 2, 0, 1'b1);
        g = 1;
        while (!mclk_tick && g < LIMIT) begin @(negedge clk); g++; end
        chk(g == 4, "R7 old ratio finishes", g, 4);
        next_tick(0, g);
        chk(g == 6, "R7 new ratio after terminal", g, 6);

        // R7: write in the terminal cycle itself, next period uses new ratio
        wait_tick(0, n);
        cfg_word = mk(0, 3, 0, 1'b1);
        next_tick(0, g);
        chk(g == 8, "R7 write on terminal cycle", g, 8);
        high_len(0, h);
        chk(h == 4, "R7 R6 no runt after reload", h, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule